// File: doc/BRIEF.md
# Battery Status Flag Tracker

This block keeps the primary status byte of a battery gauge up to date. It takes synchronised, already-digitised inputs and keeps four flags. The inputs are the result of the sense-voltage charge-qualify comparison, a discharge activity indication, the pack-voltage window comparators, a capacity-full indication, an end-of-discharge warning, a one-per-charge strobe, a capacity-learn strobe and a serially requested reset. A register-read path simply samples `flags_o`.

The flags follow different rules. The charging flag follows a qualified level. The pack-out-of-window flag follows a slow, debounced level. The replaced flag is sticky: it is set by a pack insertion or by any reset, and it is cleared only by specific charge events. The capacity-inaccurate flag is raised once enough charges have accumulated since the last capacity learn.

Top module: `batt_flag_tracker`

## Requirements
- R1: Bit 7 (charging) equals, one clock after sampling, `sense_above_i & ~dsg_act_i`. Discharge activity or a sense voltage below the threshold clears it.
- R2: Bit 5 (pack out of window) takes the value of `pack_hi_i | pack_lo_i` only after that value has differed from the flag for FILT_TICKS consecutive `tick_i` pulses. A return to agreement restarts the count, and clock cycles without a tick do not count.
- R3: Bit 5 is not sticky. Once the pack is back inside the window for FILT_TICKS ticks, it reads 0 again.
- R4: Bit 6 (replaced) is set in the same cycle that bit 5 falls from 1 to 0, because the pack has entered the window from above or below. Bit 5 rising does not set it. A set event takes priority over a clear in the same cycle.
- R5: Bit 6 clears on a `chg_evt_i` strobe while `cap_full_i` is 1.
- R6: Bit 6 clears on a `chg_evt_i` strobe that follows an `edv_warn_i` seen since bit 6 was last set. A charge with neither condition leaves it at 1.
- R7: Bit 4 (capacity inaccurate) rises on the CI_CHARGES-th (64th) `chg_evt_i` since the last learn. After 63 charges it is still 0, and further charges keep it at 1 while the counter saturates.
- R8: `learn_i` clears bit 4 and the charge count. A charge in the same cycle as the learn is not counted.
- R9: `rst_n` low (synchronous) gives `flags_o = 8'h50`. A `reset_req_i` pulse sets bits 6 and 4, clears the charge count and the insertion-warning memory, and leaves bits 7 and 5 alone.
- R10: Bits 3 to 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Filter time-base strobe (e.g. 1 Hz) |
| sense_above_i | input | 1 | Sense voltage above charge-qualify threshold |
| dsg_act_i | input | 1 | Discharge activity present |
| pack_hi_i | input | 1 | Pack voltage above upper window limit |
| pack_lo_i | input | 1 | Pack voltage below lower window limit |
| chg_evt_i | input | 1 | One-cycle strobe per valid charge action |
| cap_full_i | input | 1 | Available capacity equals full capacity |
| edv_warn_i | input | 1 | End-of-discharge warning asserted |
| learn_i | input | 1 | Capacity-learn update strobe |
| reset_req_i | input | 1 | Serially requested reset strobe |
| flags_o | output | 8 | Status byte: {charging, replaced, out-of-window, cap-inaccurate, 4'b0} |

## Verification
The hardest state to reach is the capacity-inaccurate edge, because it needs exactly 63 and then 64 charge strobes with no learn in between. The bench reaches it again after a learn that coincides with a charge, which shows that the count really restarts. The filter boundary is also hard to reach. The bench holds the window input for one tick fewer than the limit, then breaks the run partway and restarts it, so the flag must change on the exact final tick. In that same cycle the bench confirms that the replaced flag is raised by the filtered fall.

// File: rtl/batt_flag_pkg.sv
// Shared constants for the battery status flag tracker.
// Assumes an 8-bit status byte; bit positions are fixed by the read decoder.
package batt_flag_pkg;
    localparam int FLAG_W    = 8;
    localparam int CHGS_POS  = 7;
    localparam int BRP_POS   = 6;
    localparam int BRM_POS   = 5;
    localparam int CI_POS    = 4;
endpackage

// File: rtl/bft_window_filter.sv
// Debounces the pack out-of-window level against a slow tick.
// The output changes only after the raw level has disagreed with it for
// FILT_TICKS consecutive ticks. fall_o pulses in the cycle the output
// commits from 1 to 0. Assumes raw_i is already synchronised.
module bft_window_filter #(
    parameter int FILT_TICKS = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic raw_i,
    output logic level_o,
    output logic fall_o
);
    localparam int CW = $clog2(FILT_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          lvl_q;
    logic          commit;

    // commit when the final qualifying tick of a disagreement run arrives
    assign commit = (raw_i != lvl_q) && tick_i && (cnt_q == LAST);
    assign fall_o = commit && !raw_i;
    assign level_o = lvl_q;

    // run counter and filtered level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lvl_q <= 1'b0;
        end else if (raw_i == lvl_q) begin
            cnt_q <= '0;
        end else if (commit) begin
            cnt_q <= '0;
            lvl_q <= raw_i;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2
    // no_tick_hold_chk
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(lvl_q));

    // R3
    // agree_hold_chk
    agree_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_i == lvl_q) |=> (lvl_q == $past(lvl_q)));
endmodule

// File: rtl/bft_charge_counter.sv
// Counts valid charges since the last capacity learn and raises the
// capacity-inaccurate flag on the CI_CHARGES-th one. Saturates at the limit.
// Any reset sets the flag; a learn clears it. Reset request beats learn,
// and learn beats a coincident charge.
module bft_charge_counter #(
    parameter int CI_CHARGES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reset_req_i,
    input  logic learn_i,
    input  logic chg_evt_i,
    output logic ci_o
);
    localparam int CW = $clog2(CI_CHARGES + 1);
    localparam logic [CW-1:0] LIM = CW'(CI_CHARGES);

    logic [CW-1:0] cnt_q;
    logic          ci_q;

    assign ci_o = ci_q;

    // charge count and inaccurate flag
    always_ff @(posedge clk) begin
        if (!rst_n || reset_req_i) begin
            cnt_q <= '0;
            ci_q  <= 1'b1;
        end else if (learn_i) begin
            cnt_q <= '0;
            ci_q  <= 1'b0;
        end else if (chg_evt_i && (cnt_q != LIM)) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LIM - 1'b1)
                ci_q <= 1'b1;
        end
    end

    // R7
    // cnt_sat_chk
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM);

    // R7
    // ci_rise_chk
    ci_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_evt_i && !learn_i && !reset_req_i && cnt_q == LIM - 1'b1) |=> ci_q);

    // R8
    // learn_clr_chk
    learn_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (learn_i && !reset_req_i) |=> (!ci_q && cnt_q == '0));
endmodule

// File: rtl/bft_replaced_flag.sv
// Sticky pack-replaced flag. It is set by an insertion event (filtered
// window entry) or by any reset. It clears on a charge at full capacity,
// or on a charge after an end-of-discharge warning seen since the last set.
// A set takes priority over a clear.
module bft_replaced_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic reset_req_i,
    input  logic ins_evt_i,
    input  logic chg_evt_i,
    input  logic cap_full_i,
    input  logic edv_warn_i,
    output logic brp_o
);
    logic brp_q;
    logic edv_seen_q;
    logic set_ev;
    logic clr_ev;

    assign set_ev = reset_req_i || ins_evt_i;
    assign clr_ev = chg_evt_i && (cap_full_i || edv_seen_q);
    assign brp_o  = brp_q;

    // memory of an end-of-discharge warning since the last set
    always_ff @(posedge clk) begin
        if (!rst_n || set_ev)
            edv_seen_q <= 1'b0;
        else if (edv_warn_i)
            edv_seen_q <= 1'b1;
    end

    // sticky replaced flag
    always_ff @(posedge clk) begin
        if (!rst_n || set_ev)
            brp_q <= 1'b1;
        else if (clr_ev)
            brp_q <= 1'b0;
    end

    // R9
    // req_set_chk
    req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_i |=> brp_q);

    // R5
    // full_clr_chk
    full_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_evt_i && cap_full_i && !reset_req_i && !ins_evt_i) |=> !brp_q);

    // R6
    // no_cause_hold_chk
    no_cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brp_q && !chg_evt_i) |=> brp_q);
endmodule

// File: rtl/batt_flag_tracker.sv
// Top of the battery status flag tracker. It assembles the status byte
// from the charging flag, the sticky replaced flag, the filtered
// out-of-window level and the capacity-inaccurate flag. All inputs are
// assumed synchronous to clk.
module batt_flag_tracker
    import batt_flag_pkg::*;
#(
    parameter int FILT_TICKS = 30,
    parameter int CI_CHARGES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              sense_above_i,
    input  logic              dsg_act_i,
    input  logic              pack_hi_i,
    input  logic              pack_lo_i,
    input  logic              chg_evt_i,
    input  logic              cap_full_i,
    input  logic              edv_warn_i,
    input  logic              learn_i,
    input  logic              reset_req_i,
    output logic [FLAG_W-1:0] flags_o
);
    logic chgs_q;
    logic brm;
    logic ins_evt;
    logic brp;
    logic ci;

    // charging flag: qualified sense level without discharge
    always_ff @(posedge clk) begin
        if (!rst_n)
            chgs_q <= 1'b0;
        else
            chgs_q <= sense_above_i && !dsg_act_i;
    end

    bft_window_filter #(.FILT_TICKS(FILT_TICKS)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .raw_i   (pack_hi_i || pack_lo_i),
        .level_o (brm),
        .fall_o  (ins_evt)
    );

    bft_replaced_flag u_brp (
        .clk         (clk),
        .rst_n       (rst_n),
        .reset_req_i (reset_req_i),
        .ins_evt_i   (ins_evt),
        .chg_evt_i   (chg_evt_i),
        .cap_full_i  (cap_full_i),
        .edv_warn_i  (edv_warn_i),
        .brp_o       (brp)
    );

    bft_charge_counter #(.CI_CHARGES(CI_CHARGES)) u_ci (
        .clk         (clk),
        .rst_n       (rst_n),
        .reset_req_i (reset_req_i),
        .learn_i     (learn_i),
        .chg_evt_i   (chg_evt_i),
        .ci_o        (ci)
    );

    // assemble the status byte; unassigned bits read 0
    always_comb begin
        flags_o           = '0;
        flags_o[CHGS_POS] = chgs_q;
        flags_o[BRP_POS]  = brp;
        flags_o[BRM_POS]  = brm;
        flags_o[CI_POS]   = ci;
    end

    // R1
    // dsg_clear_chk
    dsg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsg_act_i |=> !flags_o[CHGS_POS]);

    // R4
    // ins_set_chk
    ins_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brm && !$past(brm)) |-> brp == $past(brp) || $past(reset_req_i));

    // R4
    // fall_sets_chk
    fall_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_evt |=> (brp && !brm));
endmodule

// File: tb/test_batt_flag_tracker.sv
module test_batt_flag_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0, sense_above_i = 1'b0, dsg_act_i = 1'b0;
    logic       pack_hi_i = 1'b0, pack_lo_i = 1'b0, chg_evt_i = 1'b0;
    logic       cap_full_i = 1'b0, edv_warn_i = 1'b0, learn_i = 1'b0;
    logic       reset_req_i = 1'b0;
    logic [7:0] flags_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    batt_flag_tracker i_batt_flag_tracker (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .sense_above_i(sense_above_i), .dsg_act_i(dsg_act_i),
        .pack_hi_i(pack_hi_i), .pack_lo_i(pack_lo_i),
        .chg_evt_i(chg_evt_i), .cap_full_i(cap_full_i),
        .edv_warn_i(edv_warn_i), .learn_i(learn_i),
        .reset_req_i(reset_req_i), .flags_o(flags_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic charges(input int n);
        for (int i = 0; i < n; i++) begin
            chg_evt_i = 1'b1; step(1);
        end
        chg_evt_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1; step(1);
        end
        tick_i = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; step(2);
        chk("R9 reset byte", flags_o, 8'h50);
        chk("R10 low nibble", {4'h0, flags_o[3:0]}, 8'h00);
        rst_n = 1'b1; step(1);
        chk("R9 after release", flags_o, 8'h50);
    endtask

    task automatic t_chgs;
        sense_above_i = 1'b1; step(1);
        chk("R1 qualify", {7'b0, flags_o[7]}, 8'd1);
        dsg_act_i = 1'b1; step(1);
        chk("R1 discharge", {7'b0, flags_o[7]}, 8'd0);
        dsg_act_i = 1'b0; step(1);
        chk("R1 requalify", {7'b0, flags_o[7]}, 8'd1);
        sense_above_i = 1'b0; step(1);
        chk("R1 below threshold", {7'b0, flags_o[7]}, 8'd0);
    endtask

    task automatic t_ci;
        learn_i = 1'b1; step(1); learn_i = 1'b0;
        chk("R8 learn clears", {7'b0, flags_o[4]}, 8'd0);
        charges(63);
        chk("R7 63 charges", {7'b0, flags_o[4]}, 8'd0);
        chk("R6 bare charges keep replaced", {7'b0, flags_o[6]}, 8'd1);
        charges(1);
        chk("R7 64th charge", {7'b0, flags_o[4]}, 8'd1);
        charges(3);
        chk("R7 saturate", {7'b0, flags_o[4]}, 8'd1);
        learn_i = 1'b1; chg_evt_i = 1'b1; step(1);
        learn_i = 1'b0; chg_evt_i = 1'b0;
        chk("R8 learn beats charge", {7'b0, flags_o[4]}, 8'd0);
        charges(63);
        chk("R8 count restarted", {7'b0, flags_o[4]}, 8'd0);
        charges(1);
        chk("R7 64th after restart", {7'b0, flags_o[4]}, 8'd1);
    endtask

    task automatic t_brp;
        cap_full_i = 1'b1; charges(1); cap_full_i = 1'b0;
        chk("R5 full charge clears", {7'b0, flags_o[6]}, 8'd0);
        sense_above_i = 1'b1; step(1);
        reset_req_i = 1'b1; step(1); reset_req_i = 1'b0;
        chk("R9 request sets", flags_o, 8'hD0);
        edv_warn_i = 1'b1; step(1); edv_warn_i = 1'b0;
        chk("R6 warning alone", {7'b0, flags_o[6]}, 8'd1);
        charges(1);
        chk("R6 charge after warning", {7'b0, flags_o[6]}, 8'd0);
        sense_above_i = 1'b0; step(1);
    endtask

    task automatic t_brm;
        pack_hi_i = 1'b1; ticks(29);
        chk("R2 one tick short", {7'b0, flags_o[5]}, 8'd0);
        ticks(1);
        chk("R2 final tick", {7'b0, flags_o[5]}, 8'd1);
        chk("R4 rise does not set", {7'b0, flags_o[6]}, 8'd0);
        pack_hi_i = 1'b0; ticks(20);
        pack_hi_i = 1'b1; step(1);
        pack_hi_i = 1'b0; ticks(29);
        chk("R2 restart after agree", {7'b0, flags_o[5]}, 8'd1);
        ticks(1);
        chk("R3 back in window", {7'b0, flags_o[5]}, 8'd0);
        chk("R4 entry sets replaced", {7'b0, flags_o[6]}, 8'd1);
        pack_lo_i = 1'b1; step(40);
        chk("R2 no tick no change", {7'b0, flags_o[5]}, 8'd0);
        ticks(30);
        chk("R2 low side", {7'b0, flags_o[5]}, 8'd1);
        chk("R10 low nibble", {4'h0, flags_o[3:0]}, 8'h00);
        pack_lo_i = 1'b0;
    endtask

    initial begin
        step(1);
        t_reset;
        t_chgs;
        t_ci;
        t_brp;
        t_brm;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule